// File: doc/BRIEF.md
# Polling Hysteresis Thermostat Controller

This block is a small bus master that runs a climate-control loop without any processor. It keeps polling a memory-mapped temperature sensor, fetches the setpoint and a status byte held in external memory, and decides whether the cooler or the heater should change state. When a change is due, it writes a one-byte command to an output port. It then records the new plant state by rewriting the status byte. The sensor, the plant and the memory all sit outside the block on a simple synchronous bus.

A hysteresis band of two counts around the setpoint prevents chatter. Cooling starts only above the upper band edge and stops only when the temperature is back at or below the setpoint. Heating works the same way on the lower side. Because the on/off state is kept in memory, and not in private flags, any other bus agent can inspect it or preset it between passes.

Top module: `thermo_poll_ctrl`

## Requirements
- R1: While `rst_n` is low both strobes stay low. The first bus access after reset is a read of the temperature port at address 0xFFFF.
- R2: Each pass reads 0xFFFF, then the setpoint at 0xFFFE, then the status byte at 0x1000. Each read is a one-cycle strobe followed by one idle cycle in which the returned byte is captured. An evaluation cycle comes next. A read and a write are never strobed together.
- R3: With status 0x00 and a temperature above the upper limit (setpoint + 2), the block writes code 0x01 to 0xFFFD in the cycle after evaluation. It writes 0xFE to 0x1000 in the cycle after that.
- R4: With status 0x00 and a temperature below the lower limit (setpoint − 2), the block writes code 0x03 to 0xFFFD and then 0xFF to 0x1000.
- R5: With status 0xFE and a temperature at or below the setpoint, the block writes code 0x02 to 0xFFFD and then 0x00 to 0x1000.
- R6: With status 0xFF and a temperature at or above the setpoint, the block writes code 0x04 to 0xFFFD and then 0x00 to 0x1000.
- R7: When none of R3–R6 applies, the pass makes no write. The next read of 0xFFFF follows the evaluation cycle directly.
- R8: The limits are unsigned 8-bit values that saturate at 0x00 and 0xFF instead of wrapping. So a setpoint of 0xFE or 0xFF can never start cooling, and a setpoint of 0x00, 0x01 or 0x02 with temperature 0x00 can never start heating.
- R9: A pass issues at most one command, and every command write is followed at once by a status write. An "on" code is issued only when the status read was 0x00. A status other than 0x00, 0xFE or 0xFF produces no command.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and control clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_rdata | input | 8 | Read data, valid in the cycle after a read strobe |
| bus_rd | output | 1 | Read strobe, one cycle per access |
| bus_wr | output | 1 | Write strobe, one cycle per access |
| bus_addr | output | 16 | Byte address of the current access |
| bus_wdata | output | 8 | Write data, valid with `bus_wr` |

## Verification
Two decisions can become true in the same evaluation. One is the switch-off of the active device. The other is the switch-on of the opposite device, when the temperature has swung across the whole band in one poll. The bench provokes this in two ways. It presets the status to cooling and presents a temperature far below the lower limit. It also presets heating and presents a temperature far above the upper limit. A correct result is a single off command in that pass with the status cleared, followed by the opposite on command only in the next pass, which reads the freshly cleared status.

// File: rtl/thermo_pkg.sv
`timescale 1ns/1ps
package thermo_pkg;
  typedef logic [7:0] byte_t;

  localparam byte_t CODE_COOL_ON  = 8'h01;
  localparam byte_t CODE_COOL_OFF = 8'h02;
  localparam byte_t CODE_HEAT_ON  = 8'h03;
  localparam byte_t CODE_HEAT_OFF = 8'h04;

  localparam byte_t STAT_IDLE = 8'h00;
  localparam byte_t STAT_COOL = 8'hFE;
  localparam byte_t STAT_HEAT = 8'hFF;

  typedef enum logic [3:0] {
    PH_IDLE, PH_RD_TEMP, PH_CAP_TEMP, PH_RD_SET, PH_CAP_SET,
    PH_RD_STAT, PH_CAP_STAT, PH_EVAL, PH_WR_CMD, PH_WR_STAT
  } phase_e;

  // Setpoint plus band, clamped at the top of the byte range.
  function automatic byte_t upper_limit(byte_t sp, byte_t band);
    logic [8:0] sum;
    sum = {1'b0, sp} + {1'b0, band};
    return sum[8] ? 8'hFF : sum[7:0];
  endfunction

  // Setpoint minus band, clamped at zero.
  function automatic byte_t lower_limit(byte_t sp, byte_t band);
    return (sp < band) ? 8'h00 : byte_t'(sp - band);
  endfunction
endpackage

// File: rtl/thermo_decide.sv
`timescale 1ns/1ps
module thermo_decide
  import thermo_pkg::*;
#(
  parameter int unsigned BAND = 2
) (
  input  byte_t temp,
  input  byte_t setp,
  input  byte_t stat,
  output logic  fire,
  output byte_t code,
  output byte_t next_stat
);
  localparam byte_t BAND_B = byte_t'(BAND);

  byte_t hi_lim, lo_lim;
  logic  too_hot, too_cold, cooled_down, warmed_up;
  logic  is_idle, is_cool, is_heat;

  assign hi_lim      = upper_limit(setp, BAND_B);
  assign lo_lim      = lower_limit(setp, BAND_B);
  assign too_hot     = temp > hi_lim;
  assign too_cold    = temp < lo_lim;
  assign cooled_down = temp <= setp;
  assign warmed_up   = temp >= setp;
  assign is_idle     = stat == STAT_IDLE;
  assign is_cool     = stat == STAT_COOL;
  assign is_heat     = stat == STAT_HEAT;

  always_comb begin
    fire      = 1'b0;
    code      = 8'h00;
    next_stat = stat;
    if (is_idle && too_hot) begin
      fire = 1'b1; code = CODE_COOL_ON;  next_stat = STAT_COOL;
    end else if (is_idle && too_cold) begin
      fire = 1'b1; code = CODE_HEAT_ON;  next_stat = STAT_HEAT;
    end else if (is_cool && cooled_down) begin
      fire = 1'b1; code = CODE_COOL_OFF; next_stat = STAT_IDLE;
    end else if (is_heat && warmed_up) begin
      fire = 1'b1; code = CODE_HEAT_OFF; next_stat = STAT_IDLE;
    end
  end
endmodule

// File: rtl/thermo_sequencer.sv
`timescale 1ns/1ps
module thermo_sequencer
  import thermo_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter logic [AW-1:0] ADDR_TEMP = 'hFFFF,
  parameter logic [AW-1:0] ADDR_SET  = 'hFFFE,
  parameter logic [AW-1:0] ADDR_CMD  = 'hFFFD,
  parameter logic [AW-1:0] ADDR_STAT = 'h1000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  byte_t         rdata,
  input  logic          fire,
  input  byte_t         code,
  input  byte_t         next_stat,
  output logic          rd,
  output logic          wr,
  output logic [AW-1:0] addr,
  output byte_t         wdata,
  output byte_t         temp_q,
  output byte_t         setp_q,
  output byte_t         stat_q,
  output logic          eval_now
);
  phase_e ph, ph_nx;
  byte_t  code_q, nstat_q;

  always_comb begin
    ph_nx = ph;
    unique case (ph)
      PH_IDLE:     ph_nx = PH_RD_TEMP;
      PH_RD_TEMP:  ph_nx = PH_CAP_TEMP;
      PH_CAP_TEMP: ph_nx = PH_RD_SET;
      PH_RD_SET:   ph_nx = PH_CAP_SET;
      PH_CAP_SET:  ph_nx = PH_RD_STAT;
      PH_RD_STAT:  ph_nx = PH_CAP_STAT;
      PH_CAP_STAT: ph_nx = PH_EVAL;
      PH_EVAL:     ph_nx = fire ? PH_WR_CMD : PH_RD_TEMP;
      PH_WR_CMD:   ph_nx = PH_WR_STAT;
      PH_WR_STAT:  ph_nx = PH_RD_TEMP;
      default:     ph_nx = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph      <= PH_IDLE;
      temp_q  <= '0;
      setp_q  <= '0;
      stat_q  <= '0;
      code_q  <= '0;
      nstat_q <= '0;
    end else begin
      ph <= ph_nx;
      if (ph == PH_CAP_TEMP) temp_q <= rdata;
      if (ph == PH_CAP_SET)  setp_q <= rdata;
      if (ph == PH_CAP_STAT) stat_q <= rdata;
      if (ph == PH_EVAL) begin
        code_q  <= code;
        nstat_q <= next_stat;
      end
    end
  end

  assign eval_now = ph == PH_EVAL;
  assign rd = (ph == PH_RD_TEMP) || (ph == PH_RD_SET) || (ph == PH_RD_STAT);
  assign wr = (ph == PH_WR_CMD) || (ph == PH_WR_STAT);

  always_comb begin
    addr  = '0;
    wdata = '0;
    unique case (ph)
      PH_RD_TEMP: addr = ADDR_TEMP;
      PH_RD_SET:  addr = ADDR_SET;
      PH_RD_STAT: addr = ADDR_STAT;
      PH_WR_CMD:  begin addr = ADDR_CMD;  wdata = code_q;  end
      PH_WR_STAT: begin addr = ADDR_STAT; wdata = nstat_q; end
      default:    addr = '0;
    endcase
  end
endmodule

// File: rtl/thermo_poll_ctrl.sv
`timescale 1ns/1ps
module thermo_poll_ctrl
  import thermo_pkg::*;
#(
  parameter int unsigned AW   = 16,
  parameter int unsigned BAND = 2,
  parameter logic [AW-1:0] ADDR_TEMP = 'hFFFF,
  parameter logic [AW-1:0] ADDR_SET  = 'hFFFE,
  parameter logic [AW-1:0] ADDR_CMD  = 'hFFFD,
  parameter logic [AW-1:0] ADDR_STAT = 'h1000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [7:0]    bus_rdata,
  output logic          bus_rd,
  output logic          bus_wr,
  output logic [AW-1:0] bus_addr,
  output logic [7:0]    bus_wdata
);
  byte_t temp_q, setp_q, stat_q, code, next_stat;
  logic  fire, eval_now;

  thermo_decide #(.BAND(BAND)) u_decide (
    .temp(temp_q), .setp(setp_q), .stat(stat_q),
    .fire(fire), .code(code), .next_stat(next_stat)
  );

  thermo_sequencer #(
    .AW(AW), .ADDR_TEMP(ADDR_TEMP), .ADDR_SET(ADDR_SET),
    .ADDR_CMD(ADDR_CMD), .ADDR_STAT(ADDR_STAT)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .rdata(bus_rdata),
    .fire(fire), .code(code), .next_stat(next_stat),
    .rd(bus_rd), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .temp_q(temp_q), .setp_q(setp_q), .stat_q(stat_q), .eval_now(eval_now)
  );
endmodule

// File: rtl/thermo_poll_chk.sv
`timescale 1ns/1ps
module thermo_poll_chk #(
  parameter int unsigned AW = 16,
  parameter logic [AW-1:0] ADDR_TEMP = 'hFFFF,
  parameter logic [AW-1:0] ADDR_CMD  = 'hFFFD,
  parameter logic [AW-1:0] ADDR_STAT = 'h1000
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_rd,
  input logic          bus_wr,
  input logic [AW-1:0] bus_addr,
  input logic [7:0]    bus_wdata,
  input logic          eval_now,
  input logic          fire
);
  logic cmd_wr;
  assign cmd_wr = bus_wr && (bus_addr == ADDR_CMD);

  AST_NO_RD_WR_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n) !(bus_rd && bus_wr)); // R2
  AST_RD_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) bus_rd |=> !bus_rd); // R2
  AST_CMD_THEN_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr |=> (bus_wr && bus_addr == ADDR_STAT)); // R9
  AST_COOL_ON_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && bus_wdata == 8'h01) |=> (bus_wdata == 8'hFE)); // R3
  AST_HEAT_ON_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && bus_wdata == 8'h03) |=> (bus_wdata == 8'hFF)); // R4
  AST_COOL_OFF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && bus_wdata == 8'h02) |=> (bus_wdata == 8'h00)); // R5
  AST_HEAT_OFF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && bus_wdata == 8'h04) |=> (bus_wdata == 8'h00)); // R6
  AST_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (eval_now && !fire) |=> (!bus_wr && bus_rd && bus_addr == ADDR_TEMP)); // R7
  AST_FIRE_WRITES_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    (eval_now && fire) |=> cmd_wr); // R9
endmodule

bind thermo_poll_ctrl thermo_poll_chk #(
  .AW(AW), .ADDR_TEMP(ADDR_TEMP), .ADDR_CMD(ADDR_CMD), .ADDR_STAT(ADDR_STAT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .eval_now(eval_now), .fire(fire)
);

// File: tb/sim_thermo_poll_ctrl.sv
`timescale 1ns/1ps
module sim_thermo_poll_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_rdata = 8'h00;
  logic        bus_rd, bus_wr;
  logic [15:0] bus_addr;
  logic [7:0]  bus_wdata;

  logic [7:0] m_temp = 8'h00, m_sp = 8'h00, m_st = 8'h00, force_val = 8'h00;
  bit   force_req = 1'b0;
  bit   at_start = 1'b0;
  int   n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  thermo_poll_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .bus_rdata(bus_rdata),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata)
  );

  // Bus responder: registered read data, status byte is writable.
  always @(posedge clk) begin
    if (bus_rd) begin
      case (bus_addr)
        16'hFFFF: bus_rdata <= m_temp;
        16'hFFFE: bus_rdata <= m_sp;
        16'h1000: bus_rdata <= m_st;
        default:  bus_rdata <= 8'h00;
      endcase
    end
    if (force_req) m_st <= force_val;
    else if (bus_wr && bus_addr == 16'h1000) m_st <= bus_wdata;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Expected command and resulting status, written from the requirement text.
  task automatic model(input int t, input int sp, input int st, output int cmd, output int nst);
    int hi, lo;
    hi = (sp + 2 > 255) ? 255 : sp + 2;
    lo = (sp - 2 < 0) ? 0 : sp - 2;
    cmd = 0; nst = st;
    case (st)
      8'h00: begin
        if (t > hi)      begin cmd = 1; nst = 8'hFE; end
        else if (t < lo) begin cmd = 3; nst = 8'hFF; end
      end
      8'hFE: if (t <= sp) begin cmd = 2; nst = 0; end
      8'hFF: if (t >= sp) begin cmd = 4; nst = 0; end
      default: cmd = 0;
    endcase
  endtask

  function automatic string tag_of(input int cmd);
    case (cmd)
      1: return "R3 cooling on";
      3: return "R4 heating on";
      2: return "R5 cooling off";
      4: return "R6 heating off";
      default: return "R7 hold";
    endcase
  endfunction

  task automatic do_pass(input logic [7:0] t, input logic [7:0] sp,
                         input bit set_st, input logic [7:0] st_in, input string tag);
    int e_cmd, e_st, got_cmd, got_st, bad;
    logic [7:0] st_used;
    string lbl;
    if (!at_start) begin
      do @(negedge clk); while (!(bus_rd && bus_addr == 16'hFFFF));
    end
    at_start = 1'b0;
    m_temp = t; m_sp = sp;
    st_used = set_st ? st_in : m_st;
    if (set_st) begin force_val = st_in; force_req = 1'b1; end
    model(int'(t), int'(sp), int'(st_used), e_cmd, e_st);
    lbl = (tag == "") ? tag_of(e_cmd) : tag;
    bad = 0;
    for (int k = 1; k <= 6; k++) begin
      @(negedge clk);
      if (k == 1) force_req = 1'b0;
      if (k == 2) begin if (!(bus_rd && !bus_wr && bus_addr == 16'hFFFE)) bad = k; end
      else if (k == 4) begin if (!(bus_rd && !bus_wr && bus_addr == 16'h1000)) bad = k; end
      else if (bus_rd || bus_wr) bad = k;
    end
    chk(bad == 0, "R2 poll order (bad slot)", bad, 0);
    @(negedge clk);
    got_cmd = (bus_wr && bus_addr == 16'hFFFD) ? int'(bus_wdata) : 0;
    if (bus_rd && bus_addr == 16'hFFFF) at_start = 1'b1;
    chk(got_cmd == e_cmd, {lbl, " command"}, got_cmd, e_cmd);
    if (got_cmd == 0 && e_cmd == 0)
      chk(at_start, "R7 next temperature read follows evaluation", int'(at_start), 1);
    if (got_cmd != 0) begin
      @(negedge clk);
      got_st = (bus_wr && bus_addr == 16'h1000) ? int'(bus_wdata) : 32'h1EE;
      chk(got_st == e_st, {lbl, " R9 status write"}, got_st, e_st);
    end
  endtask

  initial begin
    #(5.0 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] sp, t, st;
    int r;
    void'($urandom(32'd4021));
    repeat (4) @(negedge clk);
    chk(!bus_rd && !bus_wr, "R1 strobes low in reset", {bus_rd, bus_wr}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(bus_rd && !bus_wr && bus_addr == 16'hFFFF, "R1 first access reads temperature",
        int'(bus_addr), 16'hFFFF);
    at_start = 1'b1;

    // Directed corner cases around setpoint 0x10.
    do_pass(8'h12, 8'h10, 1, 8'h00, "R7 at upper limit");
    do_pass(8'h13, 8'h10, 1, 8'h00, "R3 just above upper limit");
    do_pass(8'h11, 8'h10, 0, 8'h00, "R5 still above setpoint");
    do_pass(8'h10, 8'h10, 0, 8'h00, "R5 reached setpoint");
    do_pass(8'h0E, 8'h10, 1, 8'h00, "R7 at lower limit");
    do_pass(8'h0D, 8'h10, 1, 8'h00, "R4 just below lower limit");
    do_pass(8'h0F, 8'h10, 0, 8'h00, "R6 still below setpoint");
    do_pass(8'h10, 8'h10, 0, 8'h00, "R6 reached setpoint");
    // Coinciding off/opposite-on conditions.
    do_pass(8'h02, 8'h10, 1, 8'hFE, "R9 cooling off only");
    do_pass(8'h02, 8'h10, 0, 8'h00, "R4 heating on next pass");
    do_pass(8'hF0, 8'h10, 1, 8'hFF, "R9 heating off only");
    do_pass(8'hF0, 8'h10, 0, 8'h00, "R3 cooling on next pass");
    do_pass(8'hFF, 8'h10, 1, 8'h55, "R9 unknown status");
    // Saturation of the band limits.
    do_pass(8'hFF, 8'hFF, 1, 8'h00, "R8 top setpoint");
    do_pass(8'hFF, 8'hFE, 1, 8'h00, "R8 setpoint FE");
    do_pass(8'h00, 8'h00, 1, 8'h00, "R8 zero setpoint");
    do_pass(8'h00, 8'h01, 1, 8'h00, "R8 setpoint 01");
    do_pass(8'h00, 8'h02, 1, 8'h00, "R8 setpoint 02");
    do_pass(8'h00, 8'h03, 1, 8'h00, "R4 setpoint 03");

    // Constrained random passes, status usually carried in memory.
    for (int i = 0; i < 400; i++) begin
      r  = int'($urandom_range(0, 9));
      sp = (r == 0) ? 8'h00 : (r == 1) ? 8'hFF : 8'($urandom_range(0, 255));
      t  = 8'(int'(sp) + int'($urandom_range(0, 10)) - 5);
      if ($urandom_range(0, 7) == 0) t = 8'($urandom_range(0, 255));
      r  = int'($urandom_range(0, 11));
      st = (r == 0) ? 8'h00 : (r == 1) ? 8'hFE : (r == 2) ? 8'hFF : 8'($urandom_range(0, 255));
      do_pass(t, sp, (r < 4), st, "");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule